// File: doc/BRIEF.md
# ECC Memory Controller Register File

This block is the software-visible control and status store of an error-correcting memory controller. A host reaches it over a word-wide request bus. Each request carries a valid, a write flag, a byte address and write data. Nine 32-bit registers sit at consecutive word indexes. Read data comes back on a registered output one cycle after the request.

The controller configures the block through a parameter. The implementation code sets three things:
- the write masks of the enable register,
- which enable fields survive a soft reset,
- whether a small byte-wide diagnostic window exists.

The memory datapath reports faults through a one-cycle capture strobe. The strobe loads the fault status and fault address registers and may raise the single interrupt line. Software lowers that line by writing the fault status register.

There are two reset inputs. The power-on reset puts every register, including the implementation code, into its initial state. The soft reset returns the registers to their defaults, except for selected fields of the enable register.

Top module: `ecc_ctl_regs`

## Requirements
- R1: The word index is req_addr[ADDR_W-1:2], and req_addr[1:0] is ignored. The mapped indexes are:
  - 0 enable
  - 1 delay
  - 2 fault status
  - 3 video configuration
  - 4 fault address 0
  - 5 fault address 1
  - 6 diagnostic
  - 7 event count 0
  - 8 event count 1

  Indexes 9 and above read as 0, and writes to them change nothing.
- R2: A read request (req_valid=1, req_write=0) places the selected value on rd_data after the next rising clock edge. rd_data holds its value until the next read. Either reset clears rd_data to 0.
- R3: After power-on reset, enable bits [31:28] read as the implementation code IMPL, and every other enable bit reads 0.
- R4: A write to the enable register stores a value that depends on the implementation:
  - IMPL 0 stores wdata & 0x00000103.
  - IMPL 1 or 2 stores (IMPL<<28) | (wdata & 0x00000BFF).
- R5: A write to the delay register stores wdata & 0x7FFFFFFF, so bit 31 always reads 0.
- R6: A write to the fault status register does three things:
  - It stores all 32 bits.
  - It drives irq low from the next cycle.
  - It cancels any capture strobe in the same cycle, and that strobe changes neither the status nor the address registers.
- R7: Both fault address registers ignore bus writes.
- R8: Power-on reset sets the registers as follows:
  - delay = 0x00000020
  - fault address 0 = 0x07C00000
  - every other register except the enable register = 0
  - the diagnostic window bytes = 0
  - irq = 0
- R9: Soft reset keeps only part of the enable register:
  - IMPL 0 keeps only bit 8 of the enable register.
  - Other implementations keep bits [31:24], [9:2] and 11.

  The other registers take their R8 values, and irq goes low. The diagnostic window bytes are kept.
- R10: A capture strobe acts only while enable bit 0 is 1; with bit 0 clear, the strobe is ignored. A capture loads the fault status register as follows:
  - [3:0] = flt_kind, where bit 0 is correctable, bit 1 is bad slot, bit 2 is write timeout and bit 3 is uncorrectable.
  - [7:4] = flt_dword.
  - [15:8] = flt_synd.
  - bit 16 = old bit 16 OR any old bit in [3:0].
  - [31:17] = 0.

  The same capture loads fault address 0 from flt_fa0 and fault address 1 from flt_fa1.
- R11: An accepted capture sets irq when flt_kind[3] is 1, or when flt_kind[0] and enable bit 1 are both 1. Otherwise irq keeps its value.
- R12: With IMPL 0 the block has a 4-byte diagnostic window:
  - A write stores dg_wdata at byte dg_addr mod 4.
  - A read returns byte dg_addr mod 4 on dg_rdata one cycle later.

  With any other IMPL, dg_rdata is always 0.
- R13: The video configuration, diagnostic and both event count registers each store a full 32-bit write. Each one reads back independently, with no aliasing between the two event counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset with field retention, synchronous, active high |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| dg_valid | input | 1 | Diagnostic window request valid |
| dg_write | input | 1 | Diagnostic window write flag |
| dg_addr | input | DIAG_AW | Diagnostic window byte address |
| dg_wdata | input | 8 | Diagnostic window write byte |
| dg_rdata | output | 8 | Registered diagnostic window read byte |
| flt_strobe | input | 1 | One-cycle fault capture strobe |
| flt_kind | input | 4 | Fault kind bits |
| flt_dword | input | 4 | Double-word index of the fault |
| flt_synd | input | 8 | Syndrome of the fault |
| flt_fa0 | input | 32 | Value for fault address 0 |
| flt_fa1 | input | 32 | Value for fault address 1 |
| irq | output | 1 | Interrupt request |

## Verification
Every register update lands on the rising edge that samples the request, reset or strobe. Read data is due on rd_data and dg_rdata one edge after the read request. irq changes on the same edge that accepts a capture or a fault status write.

The bench drives all inputs on the falling edge and holds each one for a single edge. It samples on the falling edge after the edge where the result is due, so each result is read exactly one full cycle after its stimulus.

Two instances, one with implementation 0 and one with implementation 1, receive identical stimulus and are compared against separate arithmetic models. Those models cover enable masking, soft-reset retention and the diagnostic window.

// File: rtl/ecc_regs_pkg.sv
package ecc_regs_pkg;

    localparam int REG_W    = 32;
    localparam int NUM_REGS = 9;

    typedef enum logic [3:0] {
        IDX_ENABLE = 4'd0,
        IDX_DELAY  = 4'd1,
        IDX_FSTAT  = 4'd2,
        IDX_VIDEO  = 4'd3,
        IDX_FADDR0 = 4'd4,
        IDX_FADDR1 = 4'd5,
        IDX_DIAG   = 4'd6,
        IDX_EVCNT0 = 4'd7,
        IDX_EVCNT1 = 4'd8
    } reg_idx_e;

    typedef struct packed {
        logic [3:0] kind;
        logic [3:0] dword;
        logic [7:0] synd;
    } fault_info_t;

    localparam logic [REG_W-1:0] DELAY_WMASK = 32'h7FFF_FFFF;
    localparam logic [REG_W-1:0] DELAY_RST   = 32'h0000_0020;
    localparam logic [REG_W-1:0] FADDR0_RST  = 32'h07C0_0000;

    // bits of the enable register accepted from a bus write
    function automatic logic [REG_W-1:0] enable_wmask(int impl);
        return (impl == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
    endfunction

    // bits of the enable register that survive a soft reset
    function automatic logic [REG_W-1:0] enable_keep(int impl);
        return (impl == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
    endfunction

    // read-only implementation code in the top nibble
    function automatic logic [REG_W-1:0] impl_field(int impl);
        return 32'(impl) << 28;
    endfunction

endpackage

// File: rtl/ecc_fault_capture.sv
module ecc_fault_capture
    import ecc_regs_pkg::*;
(
    input  logic             clk,
    input  logic             clr,
    input  logic             capture_en,
    input  logic             corr_irq_en,
    input  logic             strobe,
    input  fault_info_t      info,
    input  logic [REG_W-1:0] fa0_in,
    input  logic [REG_W-1:0] fa1_in,
    input  logic             st_wr,
    input  logic [REG_W-1:0] st_wdata,
    output logic [REG_W-1:0] status_q,
    output logic [REG_W-1:0] fa0_q,
    output logic [REG_W-1:0] fa1_q,
    output logic             irq_q
);

    logic             accept;
    logic             multi;
    logic             raise;
    logic [REG_W-1:0] captured;

    assign accept   = strobe && capture_en;
    assign multi    = status_q[16] | (|status_q[3:0]);
    assign raise    = info.kind[3] | (info.kind[0] & corr_irq_en);
    assign captured = {15'd0, multi, info.synd, info.dword, info.kind};

    always_ff @(posedge clk) begin
        if (clr) begin
            status_q <= '0;
            fa0_q    <= FADDR0_RST;
            fa1_q    <= '0;
            irq_q    <= 1'b0;
        end else if (st_wr) begin
            // bus write outranks a simultaneous capture
            status_q <= st_wdata;
            irq_q    <= 1'b0;
        end else if (accept) begin
            status_q <= captured;
            fa0_q    <= fa0_in;
            fa1_q    <= fa1_in;
            if (raise) irq_q <= 1'b1;
        end
    end

endmodule

// File: rtl/ecc_diag_window.sv
module ecc_diag_window #(
    parameter bit PRESENT = 1'b1,
    parameter int AW      = 4,
    parameter int NBYTES  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  logic          write,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    localparam int SEL_W = $clog2(NBYTES);

    generate
        if (PRESENT) begin : g_window
            logic [7:0]       bytes_q [NBYTES];
            logic [SEL_W-1:0] sel;
            assign sel = addr[SEL_W-1:0];

            if (AW > SEL_W) begin : g_hi
                logic unused_hi;
                assign unused_hi = ^addr[AW-1:SEL_W];
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < NBYTES; i++) bytes_q[i] <= '0;
                    rdata <= '0;
                end else if (valid) begin
                    if (write) bytes_q[sel] <= wdata;
                    else       rdata        <= bytes_q[sel];
                end
            end
        end else begin : g_absent
            logic unused_in;
            assign unused_in = ^{clk, rst, valid, write, addr, wdata};
            assign rdata     = '0;
        end
    endgenerate

endmodule

// File: rtl/ecc_ctl_regs.sv
module ecc_ctl_regs
    import ecc_regs_pkg::*;
#(
    parameter int IMPL    = 1,
    parameter int ADDR_W  = 6,
    parameter int DIAG_AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rd_data,
    input  logic              dg_valid,
    input  logic              dg_write,
    input  logic [DIAG_AW-1:0] dg_addr,
    input  logic [7:0]        dg_wdata,
    output logic [7:0]        dg_rdata,
    input  logic              flt_strobe,
    input  logic [3:0]        flt_kind,
    input  logic [3:0]        flt_dword,
    input  logic [7:0]        flt_synd,
    input  logic [31:0]       flt_fa0,
    input  logic [31:0]       flt_fa1,
    output logic              irq
);

    localparam int IDX_W = ADDR_W - 2;
    localparam int NEVC  = 2;

    logic [IDX_W-1:0] widx;
    logic             mapped;
    reg_idx_e         sel;
    logic             wr_en;
    logic             rd_en;
    logic             clr_any;
    logic             unused_lsb;

    assign widx       = req_addr[ADDR_W-1:2];
    assign mapped     = widx < IDX_W'(NUM_REGS);
    assign sel        = reg_idx_e'(widx[3:0]);
    assign wr_en      = req_valid && req_write && mapped;
    assign rd_en      = req_valid && !req_write;
    assign clr_any    = rst || soft_rst;
    assign unused_lsb = ^req_addr[1:0];

    logic [REG_W-1:0] en_q, dly_q, vid_q, dgr_q;
    logic [REG_W-1:0] evc_q [NEVC];
    logic [REG_W-1:0] status_q, fa0_q, fa1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= impl_field(IMPL);
            dly_q <= DELAY_RST;
            vid_q <= '0;
            dgr_q <= '0;
        end else if (soft_rst) begin
            en_q  <= en_q & enable_keep(IMPL);
            dly_q <= DELAY_RST;
            vid_q <= '0;
            dgr_q <= '0;
        end else if (wr_en) begin
            case (sel)
                IDX_ENABLE: en_q  <= impl_field(IMPL) | (req_wdata & enable_wmask(IMPL));
                IDX_DELAY:  dly_q <= req_wdata & DELAY_WMASK;
                IDX_VIDEO:  vid_q <= req_wdata;
                IDX_DIAG:   dgr_q <= req_wdata;
                default: ;
            endcase
        end
    end

    // independent event count registers, one slot per index
    generate
        for (genvar g = 0; g < NEVC; g++) begin : g_evc
            localparam logic [3:0] MY_IDX = 4'(IDX_EVCNT0) + 4'(g);
            always_ff @(posedge clk) begin
                if (clr_any)
                    evc_q[g] <= '0;
                else if (wr_en && widx[3:0] == MY_IDX)
                    evc_q[g] <= req_wdata;
            end
        end
    endgenerate

    fault_info_t finfo;
    assign finfo = '{kind: flt_kind, dword: flt_dword, synd: flt_synd};

    ecc_fault_capture u_fault (
        .clk         (clk),
        .clr         (clr_any),
        .capture_en  (en_q[0]),
        .corr_irq_en (en_q[1]),
        .strobe      (flt_strobe),
        .info        (finfo),
        .fa0_in      (flt_fa0),
        .fa1_in      (flt_fa1),
        .st_wr       (wr_en && sel == IDX_FSTAT),
        .st_wdata    (req_wdata),
        .status_q    (status_q),
        .fa0_q       (fa0_q),
        .fa1_q       (fa1_q),
        .irq_q       (irq)
    );

    ecc_diag_window #(
        .PRESENT (IMPL == 0),
        .AW      (DIAG_AW),
        .NBYTES  (4)
    ) u_diag (
        .clk   (clk),
        .rst   (rst),
        .valid (dg_valid),
        .write (dg_write),
        .addr  (dg_addr),
        .wdata (dg_wdata),
        .rdata (dg_rdata)
    );

    logic [REG_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        if (mapped) begin
            case (sel)
                IDX_ENABLE: rd_mux = en_q;
                IDX_DELAY:  rd_mux = dly_q;
                IDX_FSTAT:  rd_mux = status_q;
                IDX_VIDEO:  rd_mux = vid_q;
                IDX_FADDR0: rd_mux = fa0_q;
                IDX_FADDR1: rd_mux = fa1_q;
                IDX_DIAG:   rd_mux = dgr_q;
                IDX_EVCNT0: rd_mux = evc_q[0];
                IDX_EVCNT1: rd_mux = evc_q[1];
                default:    rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (clr_any)    rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

endmodule

// File: rtl/ecc_ctl_regs_chk.sv
module ecc_ctl_regs_chk #(
    parameter int IMPL   = 1,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              soft_rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       rd_data,
    input logic              flt_strobe,
    input logic              irq
);

    localparam int IW = ADDR_W - 2;

    logic [IW-1:0] cidx;
    logic          rd_req;
    logic          wr_req;
    assign cidx   = req_addr[ADDR_W-1:2];
    assign rd_req = req_valid && !req_write;
    assign wr_req = req_valid && req_write;

    p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst || soft_rst)
        !rd_req |=> $stable(rd_data));

    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (rd_req && cidx >= IW'(9)) |=> rd_data == 32'd0);

    p_impl_code_r3: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (rd_req && cidx == IW'(0)) |=> rd_data[31:28] == 4'(IMPL));

    p_delay_msb_r5: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (rd_req && cidx == IW'(1)) |=> !rd_data[31]);

    p_irq_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_req && cidx == IW'(2)) |=> !irq);

    p_irq_source_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(flt_strobe));

endmodule

bind ecc_ctl_regs ecc_ctl_regs_chk #(.IMPL(IMPL), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .rd_data    (rd_data),
    .flt_strobe (flt_strobe),
    .irq        (irq)
);

// File: tb/ecc_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module ecc_ctl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        dg_valid = 1'b0;
    logic        dg_write = 1'b0;
    logic [3:0]  dg_addr = '0;
    logic [7:0]  dg_wdata = '0;
    logic        flt_strobe = 1'b0;
    logic [3:0]  flt_kind = '0;
    logic [3:0]  flt_dword = '0;
    logic [7:0]  flt_synd = '0;
    logic [31:0] flt_fa0 = '0;
    logic [31:0] flt_fa1 = '0;

    logic [31:0] rd0, rd1;
    logic [7:0]  dg0, dg1;
    logic        irq0, irq1;

    always #4 clk = ~clk;

    ecc_ctl_regs #(.IMPL(1)) dut_i (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd1),
        .dg_valid(dg_valid), .dg_write(dg_write), .dg_addr(dg_addr),
        .dg_wdata(dg_wdata), .dg_rdata(dg1),
        .flt_strobe(flt_strobe), .flt_kind(flt_kind), .flt_dword(flt_dword),
        .flt_synd(flt_synd), .flt_fa0(flt_fa0), .flt_fa1(flt_fa1), .irq(irq1)
    );

    ecc_ctl_regs #(.IMPL(0)) dut0_i (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd0),
        .dg_valid(dg_valid), .dg_write(dg_write), .dg_addr(dg_addr),
        .dg_wdata(dg_wdata), .dg_rdata(dg0),
        .flt_strobe(flt_strobe), .flt_kind(flt_kind), .flt_dword(flt_dword),
        .flt_synd(flt_synd), .flt_fa0(flt_fa0), .flt_fa1(flt_fa1), .irq(irq0)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    // model: slot 0 = implementation 0 instance, slot 1 = implementation 1 instance
    logic [31:0] m [2][9];
    logic        irq_m [2];
    logic [7:0]  dgm [4];

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    function automatic string tag_of(int idx);
        case (idx)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            4, 5: return "R7";
            3, 6, 7, 8: return "R13";
            default: return "R1";
        endcase
    endfunction

    task automatic mdl_power_on();
        for (int k = 0; k < 2; k++) begin
            m[k][0] = (k == 0) ? 32'h0 : 32'h1000_0000;
            m[k][1] = 32'h20;
            m[k][4] = 32'h07C0_0000;
            m[k][2] = 0; m[k][3] = 0; m[k][5] = 0; m[k][6] = 0; m[k][7] = 0; m[k][8] = 0;
            irq_m[k] = 1'b0;
        end
        for (int b = 0; b < 4; b++) dgm[b] = 8'h00;
    endtask

    task automatic mdl_soft();
        m[0][0] = m[0][0] & 32'h0000_0100;
        m[1][0] = m[1][0] & 32'hFF00_0BFC;
        for (int k = 0; k < 2; k++) begin
            m[k][1] = 32'h20;
            m[k][4] = 32'h07C0_0000;
            m[k][2] = 0; m[k][3] = 0; m[k][5] = 0; m[k][6] = 0; m[k][7] = 0; m[k][8] = 0;
            irq_m[k] = 1'b0;
        end
    endtask

    task automatic mdl_write(int idx, logic [31:0] d);
        for (int k = 0; k < 2; k++) begin
            case (idx)
                0: m[k][0] = (k == 0) ? (d & 32'h0000_0103) : (32'h1000_0000 | (d & 32'h0000_0BFF));
                1: m[k][1] = d & 32'h7FFF_FFFF;
                2: begin m[k][2] = d; irq_m[k] = 1'b0; end
                3, 6, 7, 8: m[k][idx] = d;
                default: ;
            endcase
        end
    endtask

    task automatic bus_write(int idx, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = 6'(idx * 4 + (idx % 4)); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        mdl_write(idx, d);
    endtask

    task automatic bus_read(int idx, output logic [31:0] v0, output logic [31:0] v1);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 6'(idx * 4 + ((idx + 1) % 4));
        @(negedge clk);
        req_valid = 1'b0;
        v0 = rd0; v1 = rd1;
    endtask

    task automatic verify_all(string phase);
        logic [31:0] v0, v1, e;
        for (int idx = 0; idx < 16; idx++) begin
            bus_read(idx, v0, v1);
            for (int k = 0; k < 2; k++) begin
                e = (idx < 9) ? m[k][idx] : 32'h0;
                check(tag_of(idx), $sformatf("%s impl%0d idx=%0d", phase, k, idx),
                      (k == 0) ? v0 : v1, e);
            end
        end
        check("R11", {phase, " irq impl0"}, 32'(irq0), 32'(irq_m[0]));
        check("R11", {phase, " irq impl1"}, 32'(irq1), 32'(irq_m[1]));
    endtask

    task automatic capture(logic [3:0] kind, logic [3:0] dw, logic [7:0] sy,
                           logic [31:0] a0, logic [31:0] a1,
                           bit with_wr, logic [31:0] wd);
        logic me;
        @(negedge clk);
        flt_strobe = 1'b1; flt_kind = kind; flt_dword = dw; flt_synd = sy;
        flt_fa0 = a0; flt_fa1 = a1;
        if (with_wr) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = 6'd8; req_wdata = wd;
        end
        @(negedge clk);
        flt_strobe = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        for (int k = 0; k < 2; k++) begin
            if (with_wr) begin
                m[k][2] = wd; irq_m[k] = 1'b0;
            end else if (m[k][0][0]) begin
                me = m[k][2][16] | (|m[k][2][3:0]);
                m[k][2] = {15'd0, me, sy, dw, kind};
                m[k][4] = a0; m[k][5] = a1;
                if (kind[3] | (kind[0] & m[k][0][1])) irq_m[k] = 1'b1;
            end
        end
    endtask

    task automatic diag_write(int a, logic [7:0] d);
        @(negedge clk);
        dg_valid = 1'b1; dg_write = 1'b1; dg_addr = 4'(a); dg_wdata = d;
        @(negedge clk);
        dg_valid = 1'b0; dg_write = 1'b0;
        dgm[a % 4] = d;
    endtask

    task automatic diag_check(string phase);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            dg_valid = 1'b1; dg_write = 1'b0; dg_addr = 4'(a);
            @(negedge clk);
            dg_valid = 1'b0;
            check("R12", $sformatf("%s impl0 dg_addr=%0d", phase, a), 32'(dg0), 32'(dgm[a % 4]));
            check("R12", $sformatf("%s impl1 dg_addr=%0d", phase, a), 32'(dg1), 32'h0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        logic [31:0] pats [6];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'hA5A5_A5A5;
        pats[3] = 32'h5A5A_5A5A; pats[4] = 32'h8000_0001; pats[5] = 32'h7FFF_FFFE;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        mdl_power_on();
        check("R2", "rd_data after power-on impl0", rd0, 32'h0);
        check("R2", "rd_data after power-on impl1", rd1, 32'h0);
        verify_all("R8 R3 power-on");
        diag_check("R8 power-on");

        // sweep every index with several patterns (R1 R4 R5 R7 R13)
        for (int p = 0; p < 6; p++) begin
            for (int idx = 0; idx < 16; idx++) begin
                bus_write(idx, pats[p] ^ (32'h0101_0101 * 32'(idx)));
                verify_all($sformatf("sweep p%0d w%0d", p, idx));
            end
        end

        // soft reset retention (R9)
        bus_write(0, 32'hFFFF_FFFF);
        bus_write(6, 32'h1234_5678);
        bus_write(8, 32'hCAFE_F00D);
        diag_write(1, 8'h5C);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        mdl_soft();
        check("R2", "rd_data after soft reset impl1", rd1, 32'h0);
        verify_all("R9 soft reset");
        diag_check("R9 soft reset keeps window");

        // captures (R10 R11)
        bus_write(0, 32'h0000_0003);
        bus_write(2, 32'h0);
        capture(4'h1, 4'h5, 8'h3C, 32'hDEAD_0001, 32'hBEEF_0001, 1'b0, 32'h0);
        verify_all("R11 correctable with irq enabled");
        bus_write(2, 32'h0);
        verify_all("R6 status write clears irq");
        bus_write(0, 32'h0000_0001);
        capture(4'h1, 4'h2, 8'h11, 32'h0000_1111, 32'h0000_2222, 1'b0, 32'h0);
        verify_all("R11 correctable with irq disabled");
        capture(4'h8, 4'h9, 8'hE7, 32'h0000_3333, 32'h0000_4444, 1'b0, 32'h0);
        verify_all("R10 uncorrectable sets multi-error");
        capture(4'h2, 4'h1, 8'h00, 32'h0000_5555, 32'h0000_6666, 1'b0, 32'h0);
        verify_all("R11 bad slot leaves irq");
        capture(4'h8, 4'h3, 8'h44, 32'h0000_7777, 32'h0000_8888, 1'b1, 32'h0003_00F0);
        verify_all("R6 write beats capture");
        bus_write(0, 32'h0000_0002);
        capture(4'h8, 4'hF, 8'hFF, 32'h9999_9999, 32'hAAAA_AAAA, 1'b0, 32'h0);
        verify_all("R10 capture ignored when disabled");

        // diagnostic window (R12)
        for (int a = 0; a < 8; a++) diag_write(a, 8'(8'h30 + a * 7));
        diag_check("R12 window");

        // power-on reset again (R8 R3)
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        mdl_power_on();
        verify_all("R8 R3 second power-on");
        diag_check("R8 window cleared");

        report();
    end

endmodule